// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit virtual address into a 32-bit physical address by walking a two-level page table held in memory. A requester hands over the virtual address, the access type (read or write) and the privilege (user or supervisor) through a valid/ready handshake. The walker reads the directory entry and then the leaf entry through a memory read port that allows one read in flight. It then returns the translated address with the leaf entry's flag bits, or a fault code together with the level that faulted.

The virtual address is split into three parts. The directory index is bits 31:22, the leaf index is bits 21:12 and the page offset is bits 11:0. Each table holds 1024 entries of four bytes, so every table fills exactly one 4 KiB frame. An input supplies the frame number of the directory table, and the walker latches it when it accepts a request. Every entry has the same layout. Bits 31:12 hold a frame number. Bit 0 is present, bit 1 is write-allowed, bit 2 is user-allowed, bit 5 is accessed and bit 6 is dirty. The walker only reports bits 5 and 6; it never changes them.

Top module: `xlat_walker`

## Requirements
- R1: After reset, reqReady is 1, memReqValid is 0 and rspValid is 0.
- R2: The first memory read of a walk is at address {directory frame, va[31:22], 2'b00}.
- R3: After a usable directory entry, the second read is at address {entry[31:12], va[21:12], 2'b00}.
- R4: On success, rspPaddr = {leaf[31:12], va[11:0]}, rspFlags = leaf[6:0], rspFault = 0 and rspLevel = 1.
- R5: A directory entry with bit 0 clear gives rspFault = 1 (not present) and rspLevel = 0, with exactly one memory read and no second read.
- R6: A leaf entry with bit 0 clear gives rspFault = 1 and rspLevel = 1.
- R7: A write request meets an entry with bit 1 clear, at either level. The result is rspFault = 2 (protection) at that entry's level, and a directory-level fault stops the walk after one read.
- R8: A user request meets an entry with bit 2 clear, at either level. The result is rspFault = 2 at that entry's level.
- R9: The not-present check takes priority over the protection check. On any fault, rspPaddr is 0 and rspFlags holds bits 6:0 of the faulting entry.
- R10: reqReady falls after a request is accepted and stays low until the response is accepted. Only one walk is in flight at a time.
- R11: While memReqValid is high and memReqReady is low, the read request and its address are held. While rspValid is high and rspReady is low, the response and its fields are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rootFrame | input | 20 | Frame number of the directory table |
| reqValid | input | 1 | Translation request valid |
| reqReady | output | 1 | Walker can accept a request |
| reqVaddr | input | 32 | Virtual address to translate |
| reqWrite | input | 1 | 1 = write access, 0 = read access |
| reqUser | input | 1 | 1 = user-mode access, 0 = supervisor |
| memReqValid | output | 1 | Entry read request valid |
| memReqReady | input | 1 | Memory accepts the read request |
| memReqAddr | output | 32 | Byte address of the entry to read |
| memRspValid | input | 1 | Read data valid (one cycle per read) |
| memRspData | input | 32 | Entry read from memory |
| rspValid | output | 1 | Translation result valid |
| rspReady | input | 1 | Requester accepts the result |
| rspPaddr | output | 32 | Physical address (0 on fault) |
| rspFlags | output | 7 | Bits 6:0 of the final or faulting entry |
| rspFault | output | 2 | 0 none, 1 not present, 2 protection |
| rspLevel | output | 1 | 0 directory, 1 leaf |

## Verification
The assertions assume that memory returns exactly one memRspValid pulse for each accepted read, and only while the walker waits for it. They also assume that rspReady is sampled only against a valid response. The stimulus keeps within these bounds because a single task plays both the memory and the requester. That task answers each accepted read once, after a random delay, and inserts random stalls on memReqReady and rspReady. The task also checks that the request address and the response stay stable during those stalls. Entry flags come from seeded random draws that are biased toward the present bit being set. Directed walks add the empty-directory, read-only, supervisor-only and combined-fault cases.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  // Fault codes reported on rspFault
  typedef enum logic [1:0] {
    FAULT_NONE   = 2'd0,
    FAULT_ABSENT = 2'd1,
    FAULT_PERM   = 2'd2
  } fault_e;

  // Strobes from the walk sequencer to the datapath
  typedef struct packed {
    logic latchReq;  // capture request and directory frame
    logic leafSel;   // address/level refer to the leaf table
    logic takeDir;   // store next-table frame from read data
    logic finish;    // store result from read data
  } strobes_t;

  // Entry flag positions
  localparam int unsigned BIT_PRESENT = 0;
  localparam int unsigned BIT_WRITE   = 1;
  localparam int unsigned BIT_USER    = 2;

endpackage

// File: rtl/xlat_dp.sv
module xlat_dp
  import xlat_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned IDX_W     = 10,
  parameter int unsigned OFF_W     = 12,
  parameter int unsigned ENT_SHIFT = 2,
  parameter int unsigned FLAG_W    = 7
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  strobes_t                  st,
  input  logic [ADDR_W-1:0]         reqVaddr,
  input  logic                      reqWrite,
  input  logic                      reqUser,
  input  logic [ADDR_W-OFF_W-1:0]   rootFrame,
  input  logic [ADDR_W-1:0]         memRspData,
  output logic [ADDR_W-1:0]         memReqAddr,
  output logic                      entValid,
  output logic                      entPermOk,
  output logic [ADDR_W-1:0]         rspPaddr,
  output logic [FLAG_W-1:0]         rspFlags,
  output logic [1:0]                rspFault,
  output logic                      rspLevel
);

  localparam int unsigned FRAME_W = ADDR_W - OFF_W;
  localparam int unsigned LEAF_LO = OFF_W;
  localparam int unsigned DIR_LO  = OFF_W + IDX_W;

  logic [ADDR_W-1:0]  vaQ;
  logic               wrQ;
  logic               userQ;
  logic [FRAME_W-1:0] rootQ;
  logic [FRAME_W-1:0] nextQ;
  logic [IDX_W-1:0]   idxSel;
  logic [FRAME_W-1:0] frameSel;
  logic [FRAME_W-1:0] entFrame;
  fault_e             faultNow;

  // Table index and table frame for the current level
  assign idxSel   = st.leafSel ? vaQ[LEAF_LO +: IDX_W] : vaQ[DIR_LO +: IDX_W];
  assign frameSel = st.leafSel ? nextQ : rootQ;
  assign memReqAddr = {frameSel, idxSel, {ENT_SHIFT{1'b0}}};

  // Entry decode and permission check against the latched request
  assign entFrame  = memRspData[ADDR_W-1 -: FRAME_W];
  assign entValid  = memRspData[BIT_PRESENT];
  assign entPermOk = !(wrQ && !memRspData[BIT_WRITE]) && !(userQ && !memRspData[BIT_USER]);

  always_comb begin
    if (!entValid)       faultNow = FAULT_ABSENT;
    else if (!entPermOk) faultNow = FAULT_PERM;
    else                 faultNow = FAULT_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaQ      <= '0;
      wrQ      <= 1'b0;
      userQ    <= 1'b0;
      rootQ    <= '0;
      nextQ    <= '0;
      rspPaddr <= '0;
      rspFlags <= '0;
      rspFault <= FAULT_NONE;
      rspLevel <= 1'b0;
    end else begin
      if (st.latchReq) begin
        vaQ   <= reqVaddr;
        wrQ   <= reqWrite;
        userQ <= reqUser;
        rootQ <= rootFrame;
      end
      if (st.takeDir) nextQ <= entFrame;
      if (st.finish) begin
        rspFault <= faultNow;
        rspLevel <= st.leafSel;
        rspFlags <= memRspData[FLAG_W-1:0];
        rspPaddr <= (faultNow == FAULT_NONE) ? {entFrame, vaQ[OFF_W-1:0]} : '0;
      end
    end
  end

  // R4: a clean finish passes the page offset through untouched
  p_offset_kept_r4: assert property (@(posedge clk) disable iff (!rstN)
    st.finish && entValid && entPermOk |=>
      rspFault == FAULT_NONE && rspPaddr[OFF_W-1:0] == vaQ[OFF_W-1:0]);

  // R9: a missing entry wins over protection and zeroes the address
  p_absent_first_r9: assert property (@(posedge clk) disable iff (!rstN)
    st.finish && !entValid |=> rspFault == FAULT_ABSENT && rspPaddr == '0);

endmodule

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  output logic     reqReady,
  output logic     memReqValid,
  input  logic     memReqReady,
  input  logic     memRspValid,
  input  logic     entValid,
  input  logic     entPermOk,
  output logic     rspValid,
  input  logic     rspReady,
  output strobes_t st
);

  typedef enum logic [2:0] {
    S_IDLE, S_DIR_REQ, S_DIR_WAIT, S_LEAF_REQ, S_LEAF_WAIT, S_RESP
  } state_e;

  state_e state, stateNext;
  logic   entOk;

  assign entOk = entValid && entPermOk;

  always_comb begin
    stateNext = state;
    case (state)
      S_IDLE:      if (reqValid)    stateNext = S_DIR_REQ;
      S_DIR_REQ:   if (memReqReady) stateNext = S_DIR_WAIT;
      S_DIR_WAIT:  if (memRspValid) stateNext = entOk ? S_LEAF_REQ : S_RESP;
      S_LEAF_REQ:  if (memReqReady) stateNext = S_LEAF_WAIT;
      S_LEAF_WAIT: if (memRspValid) stateNext = S_RESP;
      S_RESP:      if (rspReady)    stateNext = S_IDLE;
      default:                      stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  assign reqReady    = (state == S_IDLE);
  assign memReqValid = (state == S_DIR_REQ) || (state == S_LEAF_REQ);
  assign rspValid    = (state == S_RESP);

  always_comb begin
    st          = '0;
    st.latchReq = (state == S_IDLE) && reqValid;
    st.leafSel  = (state == S_LEAF_REQ) || (state == S_LEAF_WAIT);
    st.takeDir  = (state == S_DIR_WAIT) && memRspValid && entOk;
    st.finish   = ((state == S_DIR_WAIT) && memRspValid && !entOk) ||
                  ((state == S_LEAF_WAIT) && memRspValid);
  end

  // R10: no second request is taken while a walk is open
  p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqReady);

  // R11: read request held until taken
  p_memreq_held_r11: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> memReqValid);

  // R11: response held until taken
  p_rsp_held_r11: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspReady |=> rspValid);

  // R5: a bad directory entry ends the walk without a leaf read
  p_short_walk_r5: assert property (@(posedge clk) disable iff (!rstN)
    state == S_DIR_WAIT && memRspValid && !entValid |=> rspValid && !memReqValid);

endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xlat_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned IDX_W     = 10,
  parameter int unsigned OFF_W     = 12,
  parameter int unsigned ENT_SHIFT = 2,
  parameter int unsigned FLAG_W    = 7
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-OFF_W-1:0] rootFrame,
  input  logic                    reqValid,
  output logic                    reqReady,
  input  logic [ADDR_W-1:0]       reqVaddr,
  input  logic                    reqWrite,
  input  logic                    reqUser,
  output logic                    memReqValid,
  input  logic                    memReqReady,
  output logic [ADDR_W-1:0]       memReqAddr,
  input  logic                    memRspValid,
  input  logic [ADDR_W-1:0]       memRspData,
  output logic                    rspValid,
  input  logic                    rspReady,
  output logic [ADDR_W-1:0]       rspPaddr,
  output logic [FLAG_W-1:0]       rspFlags,
  output logic [1:0]              rspFault,
  output logic                    rspLevel
);

  strobes_t st;
  logic     entValid;
  logic     entPermOk;

  xlat_ctrl i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqReady    (reqReady),
    .memReqValid (memReqValid),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .entValid    (entValid),
    .entPermOk   (entPermOk),
    .rspValid    (rspValid),
    .rspReady    (rspReady),
    .st          (st)
  );

  xlat_dp #(
    .ADDR_W    (ADDR_W),
    .IDX_W     (IDX_W),
    .OFF_W     (OFF_W),
    .ENT_SHIFT (ENT_SHIFT),
    .FLAG_W    (FLAG_W)
  ) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .st         (st),
    .reqVaddr   (reqVaddr),
    .reqWrite   (reqWrite),
    .reqUser    (reqUser),
    .rootFrame  (rootFrame),
    .memRspData (memRspData),
    .memReqAddr (memReqAddr),
    .entValid   (entValid),
    .entPermOk  (entPermOk),
    .rspPaddr   (rspPaddr),
    .rspFlags   (rspFlags),
    .rspFault   (rspFault),
    .rspLevel   (rspLevel)
  );

  // R11: the entry address does not move while the read is stalled
  p_addr_stable_r11: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memReqReady |=> $stable(memReqAddr));

  // R11: result fields do not move while the response is stalled
  p_result_stable_r11: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && !rspReady |=> $stable(rspPaddr) && $stable(rspFault) && $stable(rspLevel));

endmodule

// File: tb/test_xlat_walker.sv
module test_xlat_walker;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [19:0] rootFrame = '0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqVaddr = '0;
  logic        reqWrite = 1'b0;
  logic        reqUser = 1'b0;
  logic        memReqValid;
  logic        memReqReady = 1'b0;
  logic [31:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic        rspValid;
  logic        rspReady = 1'b0;
  logic [31:0] rspPaddr;
  logic [6:0]  rspFlags;
  logic [1:0]  rspFault;
  logic        rspLevel;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  xlat_walker i_xlat_walker (
    .clk(clk), .rstN(rstN), .rootFrame(rootFrame),
    .reqValid(reqValid), .reqReady(reqReady), .reqVaddr(reqVaddr),
    .reqWrite(reqWrite), .reqUser(reqUser),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .rspValid(rspValid), .rspReady(rspReady), .rspPaddr(rspPaddr),
    .rspFlags(rspFlags), .rspFault(rspFault), .rspLevel(rspLevel)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Expected walk outcome from the requirements
  function automatic void model(input logic [31:0] va, input bit wr, input bit us,
                                input logic [19:0] root, input logic [31:0] de,
                                input logic [31:0] le, output int nReads,
                                output logic [1:0] f, output bit lvl,
                                output logic [31:0] pa, output logic [6:0] fl,
                                output logic [31:0] a1, output logic [31:0] a2);
    a1 = {root, va[31:22], 2'b00};
    a2 = {de[31:12], va[21:12], 2'b00};
    nReads = 1; lvl = 1'b0; pa = '0; fl = de[6:0]; f = 2'd0;
    if (!de[0]) f = 2'd1;
    else if ((wr && !de[1]) || (us && !de[2])) f = 2'd2;
    else begin
      nReads = 2; lvl = 1'b1; fl = le[6:0];
      if (!le[0]) f = 2'd1;
      else if ((wr && !le[1]) || (us && !le[2])) f = 2'd2;
      else pa = {le[31:12], va[11:0]};
    end
  endfunction

  task automatic doWalk(input logic [31:0] va, input bit wr, input bit us,
                        input logic [19:0] root, input logic [31:0] de,
                        input logic [31:0] le);
    int expReads; logic [1:0] expF; bit expL; logic [31:0] expPa;
    logic [6:0] expFl; logic [31:0] a1; logic [31:0] a2;
    int reads = 0; int cyc = 0; bit done = 0;
    model(va, wr, us, root, de, le, expReads, expF, expL, expPa, expFl, a1, a2);
    reqVaddr = va; reqWrite = wr; reqUser = us; rootFrame = root; reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    reqVaddr = $urandom; reqWrite = 1'($urandom); reqUser = 1'($urandom);
    chk(!reqReady, "R10", "ready after accept", 32'(reqReady), 0);
    while (!done && cyc < 200) begin
      if (rspValid) done = 1;
      else if (memReqValid) begin
        logic [31:0] seen;
        seen = memReqAddr;
        repeat ($urandom_range(0, 2)) begin
          memReqReady = 1'b0;
          @(negedge clk);
          chk(memReqValid && memReqAddr == seen, "R11", "stalled read addr", memReqAddr, seen);
        end
        memReqReady = 1'b1;
        @(negedge clk);
        memReqReady = 1'b0;
        reads++;
        if (reads == 1) chk(seen == a1, "R2", "directory read addr", seen, a1);
        else            chk(seen == a2, "R3", "leaf read addr", seen, a2);
        repeat ($urandom_range(0, 2)) @(negedge clk);
        memRspValid = 1'b1;
        memRspData = (reads == 1) ? de : le;
        @(negedge clk);
        memRspValid = 1'b0;
        memRspData = $urandom;
      end else @(negedge clk);
      cyc++;
    end
    chk(done == 1, "R10", "response arrived", 32'(done), 1);
    chk(reads == expReads, (expL == 0) ? "R5" : "R3", "read count", 32'(reads), 32'(expReads));
    repeat ($urandom_range(0, 2)) begin
      @(negedge clk);
      chk(rspValid && !reqReady && rspPaddr == expPa, "R11", "held response", rspPaddr, expPa);
    end
    chk(rspFault == expF, (expF == 0) ? "R4" : (expF == 1 ? "R9" : "R7"), "fault", 32'(rspFault), 32'(expF));
    chk(rspLevel == expL, (expL == 0) ? "R5" : "R6", "level", 32'(rspLevel), 32'(expL));
    chk(rspPaddr == expPa, (expF == 0) ? "R4" : "R9", "paddr", rspPaddr, expPa);
    chk(rspFlags == expFl, "R4", "flags", 32'(rspFlags), 32'(expFl));
    rspReady = 1'b1;
    @(negedge clk);
    rspReady = 1'b0;
    chk(reqReady && !rspValid, "R10", "ready after response", 32'(reqReady), 1);
  endtask

  function automatic logic [31:0] randEntry();
    logic [31:0] e;
    e = $urandom;
    e[0] = ($urandom_range(0, 7) != 0);
    e[1] = ($urandom_range(0, 3) != 0);
    e[2] = ($urandom_range(0, 3) != 0);
    return e;
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(reqReady == 1'b1, "R1", "reset reqReady", 32'(reqReady), 1);
    chk(memReqValid == 1'b0, "R1", "reset memReqValid", 32'(memReqValid), 0);
    chk(rspValid == 1'b0, "R1", "reset rspValid", 32'(rspValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    // R2 R3 R4: clean read walk, offset all ones
    doWalk(32'hFFC0_1FFF, 0, 0, 20'h12345, 32'hABCDE007, 32'h55555067);
    // R2 R3: lowest indexes
    doWalk(32'h0000_0000, 1, 1, 20'h00001, 32'h00002007, 32'hFFFFF047);
    // R5: empty directory entry
    doWalk(32'h8040_2123, 0, 0, 20'h0BEEF, 32'h12345006, 32'h00000007);
    // R6: empty leaf entry
    doWalk(32'h1234_5678, 0, 0, 20'h0CAFE, 32'h77777007, 32'h88888066);
    // R7: write to read-only leaf
    doWalk(32'h4000_3ABC, 1, 0, 20'h00F00, 32'h11111007, 32'h22222005);
    // R7: write through read-only directory entry
    doWalk(32'h4000_3ABC, 1, 0, 20'h00F00, 32'h11111005, 32'h22222007);
    // R8: user access to supervisor leaf
    doWalk(32'hDEAD_BEEF, 0, 1, 20'h00A0A, 32'h33333007, 32'h44444063);
    // R8: user access through supervisor directory entry
    doWalk(32'hDEAD_BEEF, 0, 1, 20'h00A0A, 32'h33333003, 32'h44444007);
    // R9: absent and read-only together report absent
    doWalk(32'h0040_0FFF, 1, 1, 20'h00777, 32'h99999000, 32'h0);
    doWalk(32'h0040_0FFF, 1, 1, 20'h00777, 32'h99999007, 32'h66666060);
    // random walks
    for (int i = 0; i < 80; i++) begin
      doWalk($urandom, 1'($urandom), 1'($urandom), 20'($urandom), randEntry(), randEntry());
      repeat ($urandom_range(0, 2)) @(negedge clk);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R10 watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule